// File: doc/BRIEF.md
# SMI Status Register Pair

This block holds two 8-bit system-management-interrupt status registers. They sit at offsets 12h and 13h above a power-management base address supplied on a port. The block collects interrupt indications from the peripherals around it. Most of them are levels that the block only mirrors, and software clears those at the peripheral. Three events are captured in sticky flags instead, and reading the second register clears them: an infrared receive transition, a generic B event, and a write to the sleep-enable control.

The infrared input is the output of a two-way mux controlled by a select bit. The chosen pin is synchronized, and a flag is raised on either of its edges. Flipping the select is never counted as an edge. Software reads the status over a simple I/O bus. Writes decode harmlessly and change nothing.

Top module: `smi_status_pair`

## Requirements
- R1: After reset both registers read 00h.
- R2: Register 1 (base+12h) mirrors the current input levels. Bit1 is parallel port, bit2 UART2, bit3 UART1, bit4 floppy, bit5 group 2, bit6 group 1 and bit7 watchdog. Bit0 reads 0.
- R3: Register 2 (base+13h) mirrors the current levels of mouse on bit0, keyboard on bit1 and keyboard-controller pin P1.2 on bit4. Bits 5 and 6 read 0.
- R4: A rising or falling transition on the selected IR pin sets register 2 bit2. The pin is ir_rx_a when ir_sel=0 and ir_rx_b when ir_sel=1. Transitions on the unselected pin have no effect.
- R5: Changing ir_sel while the two pins sit at different levels does not set bit2.
- R6: A one-cycle pulse on b_event sets register 2 bit3. A one-cycle pulse on slp_en_wr sets bit7. Both flags hold until cleared by R7.
- R7: A read strobe that decodes to base+13h returns the flags and clears bits 2, 3 and 7 at that clock edge. Reads of base+12h or of any other address do not clear them.
- R8: When a set event and a clearing read fall in the same cycle, the read returns the old value and the flag remains 1 afterwards.
- R9: Writes to either register leave every status bit unchanged.
- R10: io_rdata is 00h unless io_rd is high and io_addr decodes to one of the two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous battery power-on reset |
| pm_base | input | ADDR_W | Power-management block base address |
| io_addr | input | ADDR_W | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data (ignored) |
| io_rdata | output | 8 | Read data |
| par_irq | input | 1 | Parallel port interrupt level |
| uart2_irq | input | 1 | Second UART interrupt level |
| uart1_irq | input | 1 | First UART interrupt level |
| fdc_irq | input | 1 | Floppy controller interrupt level |
| grp2_irq | input | 1 | Group interrupt 2 level |
| grp1_irq | input | 1 | Group interrupt 1 level |
| wdog_irq | input | 1 | Watchdog level |
| mouse_irq | input | 1 | Mouse interrupt level |
| kbd_irq | input | 1 | Keyboard interrupt level |
| kbc_p12 | input | 1 | Keyboard-controller port pin P1.2 level |
| b_event | input | 1 | Pulse that sets the B flag |
| slp_en_wr | input | 1 | Pulse marking a write of the sleep-enable bit |
| ir_rx_a | input | 1 | IR receive pin, choice 0 (asynchronous) |
| ir_rx_b | input | 1 | IR receive pin, choice 1 (asynchronous) |
| ir_sel | input | 1 | IR pin select |

## Verification
The bench checks that the IR flag fires on both edge directions of the selected pin. A design that detects only one polarity, or listens to the wrong pin, fails here. It flips the select while the pins disagree, which catches a design that reports the switch as a false transition. It lands a B pulse on the same cycle as a clearing read, which exposes a design where the clear beats the set and loses the event. Reads of register 1, reads of unrelated addresses and writes follow set events, to catch a clear-on-read that decodes too loosely or writes that reach the flags.

// File: rtl/smi_status_pair.sv
module smi_status_pair #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_LVL = ADDR_W'('h12),
  parameter logic [ADDR_W-1:0] OFF_EVT = ADDR_W'('h13)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pm_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              par_irq,
  input  logic              uart2_irq,
  input  logic              uart1_irq,
  input  logic              fdc_irq,
  input  logic              grp2_irq,
  input  logic              grp1_irq,
  input  logic              wdog_irq,
  input  logic              mouse_irq,
  input  logic              kbd_irq,
  input  logic              kbc_p12,
  input  logic              b_event,
  input  logic              slp_en_wr,
  input  logic              ir_rx_a,
  input  logic              ir_rx_b,
  input  logic              ir_sel
);

  logic hit_lvl, hit_evt, clr;
  logic [2:0] ir_pipe, sel_pipe;
  logic ir_edge;
  logic ir_flag, b_flag, slp_flag;
  logic [7:0] reg_lvl, reg_evt;

  assign hit_lvl = io_addr == pm_base + OFF_LVL;
  assign hit_evt = io_addr == pm_base + OFF_EVT;
  assign clr     = io_rd && hit_evt;

  // each IR sample travels with the select that produced it
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir_pipe  <= '0;
      sel_pipe <= '0;
    end else begin
      ir_pipe  <= {ir_pipe[1:0], ir_sel ? ir_rx_b : ir_rx_a};
      sel_pipe <= {sel_pipe[1:0], ir_sel};
    end

  assign ir_edge = (ir_pipe[1] ^ ir_pipe[2]) && (sel_pipe[1] == sel_pipe[2]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir_flag  <= 1'b0;
      b_flag   <= 1'b0;
      slp_flag <= 1'b0;
    end else begin
      ir_flag  <= ir_edge   | (ir_flag  & ~clr);
      b_flag   <= b_event   | (b_flag   & ~clr);
      slp_flag <= slp_en_wr | (slp_flag & ~clr);
    end

  assign reg_lvl = {wdog_irq, grp1_irq, grp2_irq, fdc_irq,
                    uart1_irq, uart2_irq, par_irq, 1'b0};
  assign reg_evt = {slp_flag, 2'b00, kbc_p12, b_flag, ir_flag,
                    kbd_irq, mouse_irq};

  assign io_rdata = !io_rd  ? 8'h00 :
                    hit_lvl ? reg_lvl :
                    hit_evt ? reg_evt : 8'h00;

  logic unused_ok;
  assign unused_ok = ^{io_wr, io_wdata};

endmodule

// File: rtl/smi_status_pair_chk.sv
module smi_status_pair_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_LVL = ADDR_W'('h12),
  parameter logic [ADDR_W-1:0] OFF_EVT = ADDR_W'('h13)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pm_base,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic              b_event,
  input logic              slp_en_wr,
  input logic              b_flag,
  input logic              slp_flag
);
  logic rd_evt, rd_lvl;
  assign rd_evt = io_rd && io_addr == pm_base + OFF_EVT;
  assign rd_lvl = io_rd && io_addr == pm_base + OFF_LVL;

  p_lvl_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lvl |-> io_rdata[0] == 1'b0);
  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> io_rdata[6:5] == 2'b00);
  p_b_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_event |=> b_flag);
  p_slp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slp_en_wr |=> slp_flag);
  p_b_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_flag && !rd_evt) |=> b_flag);
  p_b_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !b_event) |=> !b_flag);
  p_slp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !slp_en_wr) |=> !slp_flag);
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);
  p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_rd && !b_event) |=> b_flag == $past(b_flag));
endmodule

bind smi_status_pair smi_status_pair_chk #(
  .ADDR_W(ADDR_W), .OFF_LVL(OFF_LVL), .OFF_EVT(OFF_EVT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_base(pm_base), .io_addr(io_addr),
  .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
  .b_event(b_event), .slp_en_wr(slp_en_wr),
  .b_flag(b_flag), .slp_flag(slp_flag)
);

// File: tb/tb_smi_status_pair.sv
module tb_smi_status_pair;
  logic clk = 0, rst_n = 0;
  logic [7:0] pm_base = 8'h40, io_addr = 0, io_wdata = 0, io_rdata;
  logic io_rd = 0, io_wr = 0;
  logic par_irq = 0, uart2_irq = 0, uart1_irq = 0, fdc_irq = 0, grp2_irq = 0,
        grp1_irq = 0, wdog_irq = 0, mouse_irq = 0, kbd_irq = 0, kbc_p12 = 0;
  logic b_event = 0, slp_en_wr = 0, ir_rx_a = 0, ir_rx_b = 0, ir_sel = 0;
  int n_chk = 0, n_bad = 0;
  logic [7:0] got;

  localparam logic [7:0] A_LVL = 8'h52, A_EVT = 8'h53;

  always #2 clk = ~clk;

  smi_status_pair dut (.*);

  // {stimulus[9:0] = wdt,g1,g2,fdc,u1,u2,par,p12,kbd,mouse ; exp reg1 ; exp reg2}
  localparam logic [25:0] VEC [13] = '{
    {10'h000, 8'h00, 8'h00}, {10'h3FF, 8'hFE, 8'h13}, {10'h001, 8'h00, 8'h01},
    {10'h002, 8'h00, 8'h02}, {10'h004, 8'h00, 8'h10}, {10'h008, 8'h02, 8'h00},
    {10'h010, 8'h04, 8'h00}, {10'h020, 8'h08, 8'h00}, {10'h040, 8'h10, 8'h00},
    {10'h080, 8'h20, 8'h00}, {10'h100, 8'h40, 8'h00}, {10'h200, 8'h80, 8'h00},
    {10'h2A5, 8'hA8, 8'h11}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic pulse_b();
    @(negedge clk); b_event = 1; @(negedge clk); b_event = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(A_LVL, got); check(got, 8'h00, "R1 reg1 reset");
    rd(A_EVT, got); check(got, 8'h00, "R1 reg2 reset");

    foreach (VEC[i]) begin
      @(negedge clk);
      {wdog_irq, grp1_irq, grp2_irq, fdc_irq, uart1_irq, uart2_irq, par_irq,
       kbc_p12, kbd_irq, mouse_irq} = VEC[i][25:16];
      rd(A_LVL, got); check(got, VEC[i][15:8], "R2 reg1 levels");
      rd(A_EVT, got); check(got, VEC[i][7:0], "R3 reg2 levels");
    end
    @(negedge clk);
    {wdog_irq, grp1_irq, grp2_irq, fdc_irq, uart1_irq, uart2_irq, par_irq,
     kbc_p12, kbd_irq, mouse_irq} = '0;

    // R10: unmapped address and idle bus
    @(negedge clk); io_addr = A_LVL; wdog_irq = 1; #1 check(io_rdata, 8'h00, "R10 no strobe");
    rd(8'h51, got); check(got, 8'h00, "R10 other address");
    wdog_irq = 0;

    // R4 rising edge on selected pin, then cleared by read (R7)
    ir_rx_a = 1; settle();
    rd(A_EVT, got); check(got, 8'h04, "R4 IR rise");
    rd(A_EVT, got); check(got, 8'h00, "R7 IR cleared");
    ir_rx_b = 1; settle();
    rd(A_EVT, got); check(got, 8'h00, "R4 unselected pin");
    ir_rx_a = 0; settle();
    rd(A_EVT, got); check(got, 8'h04, "R4 IR fall");
    // R5 select flip with pins at different levels
    ir_sel = 1; settle();
    rd(A_EVT, got); check(got, 8'h00, "R5 select switch");
    ir_rx_b = 0; settle();
    rd(A_EVT, got); check(got, 8'h04, "R4 pin b edge");

    // R6 sticky flags, R7 other reads do not clear
    pulse_b();
    @(negedge clk); slp_en_wr = 1; @(negedge clk); slp_en_wr = 0;
    settle();
    rd(A_LVL, got); check(got, 8'h00, "R7 reg1 read");
    rd(8'h10, got); check(got, 8'h00, "R7 other read");
    rd(A_EVT, got); check(got, 8'h88, "R6 sticky B and sleep");
    rd(A_EVT, got); check(got, 8'h00, "R7 flags cleared");

    // R9 writes ignored
    pulse_b();
    @(negedge clk); io_addr = A_EVT; io_wr = 1; io_wdata = 8'h00;
    @(negedge clk); io_addr = A_LVL; io_wdata = 8'hFF;
    @(negedge clk); io_wr = 0;
    rd(A_EVT, got); check(got, 8'h08, "R9 write to reg2");
    rd(A_LVL, got); check(got, 8'h00, "R9 write to reg1");

    // R8 set and clear in same cycle
    @(negedge clk); io_addr = A_EVT; io_rd = 1; b_event = 1; #1 got = io_rdata;
    @(negedge clk); io_rd = 0; b_event = 0;
    check(got, 8'h00, "R8 old value returned");
    rd(A_EVT, got); check(got, 8'h08, "R8 set wins");
    rd(A_EVT, got); check(got, 8'h00, "R8 then cleared");

    // R1 reset mid-run clears flags
    pulse_b();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(A_EVT, got); check(got, 8'h00, "R1 reset clears flags");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule